// File: doc/BRIEF.md
# Interrupt Priority Resolver

This block decides which of many interrupt requests the processor takes next. Eight special sources have a fixed rank. Reset, the non-maskable interrupt, debug, and a group of three watchdog-class sources rank above every peripheral. Single-step and address-match rank below every peripheral. Each peripheral source has a 3-bit level that software programs. A peripheral request competes only when its level is above the processor's current priority level and the global enable is set.

Request pulses are captured in a pending register, so a request that arrives between two sampling points is kept. When the sampling strobe is high and no grant is outstanding, the block picks one pending winner. It issues a registered one-cycle grant carrying the winner's source number and level. It then waits for an acknowledge, which clears that source's pending bit and allows the next grant.

Top module: `irq_resolver`

## Requirements
- R1: After reset no request is pending and `grant_valid_o` is 0, so a sampling strobe with no new request produces no grant.
- R2: A one-cycle request pulse is held as pending until it is granted. A pulse seen in cycle c can be granted by a strobe in cycle c+1 or in any later cycle.
- R3: A grant is issued only for a cycle in which `sample_i` is 1. `grant_valid_o` rises in the next cycle and stays high for exactly one cycle. Pending requests with no strobe produce no grant.
- R4: Source numbers are fixed as follows: 0 reset, 1 non-maskable, 2 debug, 3 watchdog, 4 oscillator-stop, 5 low-voltage, 6 single-step, 7 address-match, and 8+k for peripheral k. The rank from highest to lowest is 0, 1, 2, 3, 4, 5, then any eligible peripheral, then 6, then 7.
- R5: Among eligible peripherals, the one with the highest programmed level wins. The level of peripheral k is held in bits 3k+2..3k of `per_lvl_i`.
- R6: When eligible peripherals have equal levels, the lowest peripheral index wins.
- R7: A peripheral is eligible only if `gie_i` is 1 and its level is strictly greater than `cpu_ipl_i`. A level of 0 therefore never competes. A masked request stays pending and can be granted once the masking is lifted.
- R8: All eight special sources ignore `gie_i` and `cpu_ipl_i`.
- R9: `grant_lvl_o` gives the programmed level for a peripheral winner and 7 for a special winner.
- R10: After a grant, no further grant is issued until `ack_i` is seen. The acknowledge clears only the granted source's pending bit. An acknowledge while no grant is outstanding has no effect.
- R11: If a source asserts a new request in the same cycle as the acknowledge of its own grant, the request stays pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_i | input | 1 | Sampling-point strobe |
| spec_req_i | input | 8 | Special request pulses; bit n is source n |
| per_req_i | input | NUM_PERIPH | Peripheral request pulses |
| per_lvl_i | input | NUM_PERIPH*LVL_W | Programmed peripheral levels, LVL_W bits each |
| gie_i | input | 1 | Global enable for peripheral requests |
| cpu_ipl_i | input | LVL_W | Current processor priority level |
| ack_i | input | 1 | Acknowledge of the outstanding grant |
| grant_valid_o | output | 1 | One-cycle grant strobe |
| grant_src_o | output | SRC_W | Source number of the winner |
| grant_lvl_o | output | LVL_W | Level of the winner |

## Verification
The assertions take for granted that reset is held for at least one clock edge before any check. They also assume `gie_i`, `cpu_ipl_i` and `per_lvl_i` are steady in the cycle in which a strobe decides a winner. The stimulus meets both by changing configuration only at falling edges and only when no strobe is pending. It sends an acknowledge only after the one-cycle grant has been observed, except in the scenario where an acknowledge is deliberately sent with no grant outstanding.

// File: rtl/irq_pkg.sv
// Package: shared constants for the interrupt priority resolver.
// Assumes eight special sources numbered 0..7. Sources below NUM_FIXED_HI
// rank above all peripherals. Single-step and address-match rank below them.
package irq_pkg;
    localparam int NUM_SPEC     = 8;
    localparam int NUM_FIXED_HI = 6;
    localparam int SRC_SSTEP    = 6;
    localparam int SRC_AMATCH   = 7;
endpackage

// File: rtl/irq_pend.sv
// Module: pending request store.
// Each bit is set by a request pulse and cleared by its clear line.
// When set and clear hit the same bit in the same cycle, set wins.
// Assumes that at most one clear bit is high per cycle.
module irq_pend #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] pend_q;

    // Keep every request until it is cleared; a new request overrides a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | set_i;
    end

    assign pend_o = pend_q;

    // R10: a pending bit is dropped only by its own clear.
    a_r10_drop_only_on_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((($past(pend_q) & ~pend_q) & ~$past(clr_i)) == '0));

    // R11: any request seen last cycle is pending now, even against a clear.
    a_r11_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(set_i) & ~pend_q) == '0));

    // R10: at most one source is cleared per cycle.
    a_r10_clear_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_i));
endmodule

// File: rtl/irq_periph_arb.sv
// Module: peripheral arbiter.
// A peripheral is eligible when it is pending, the global enable is set,
// and its level is above the processor level. Among eligible peripherals the
// highest level wins; on equal levels the lowest index wins.
// Purely combinational. Assumes LVL_W-bit levels packed k-major in lvl_i.
module irq_periph_arb #(
    parameter int NUM_PERIPH = 8,
    parameter int LVL_W      = 3,
    localparam int IDX_W     = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
    input  logic [NUM_PERIPH-1:0]       pend_i,
    input  logic [NUM_PERIPH*LVL_W-1:0] lvl_i,
    input  logic                        gie_i,
    input  logic [LVL_W-1:0]            ipl_i,
    output logic                        found_o,
    output logic [IDX_W-1:0]            idx_o,
    output logic [LVL_W-1:0]            lvl_o
);
    logic [NUM_PERIPH-1:0] elig;

    // One eligibility test per peripheral.
    for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_elig
        assign elig[g] = pend_i[g] & gie_i & (lvl_i[g*LVL_W +: LVL_W] > ipl_i);
    end

    // Scan from index 0 upward; a strict compare keeps the lowest index on ties.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        lvl_o   = '0;
        for (int k = 0; k < NUM_PERIPH; k++) begin
            if (elig[k] && (lvl_i[k*LVL_W +: LVL_W] > lvl_o)) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(k);
                lvl_o   = lvl_i[k*LVL_W +: LVL_W];
            end
        end
    end
endmodule

// File: rtl/irq_src_sel.sv
// Module: fixed-order final selector.
// It places the peripheral winner between the upper special group (sources
// 0..5) and the lower special group (single-step, then address-match).
// Specials report the all-ones level. Purely combinational.
module irq_src_sel
    import irq_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter int LVL_W      = 3,
    parameter int SRC_W      = 4,
    parameter int IDX_W      = 3
) (
    input  logic [NUM_SPEC-1:0] spec_pend_i,
    input  logic                per_found_i,
    input  logic [IDX_W-1:0]    per_idx_i,
    input  logic [LVL_W-1:0]    per_lvl_i,
    output logic                any_o,
    output logic [SRC_W-1:0]    src_o,
    output logic [LVL_W-1:0]    lvl_o
);
    // Apply candidates from lowest to highest rank; later assignments override.
    always_comb begin
        any_o = 1'b0;
        src_o = '0;
        lvl_o = '0;
        if (spec_pend_i[SRC_AMATCH]) begin
            any_o = 1'b1;
            src_o = SRC_W'(SRC_AMATCH);
            lvl_o = '1;
        end
        if (spec_pend_i[SRC_SSTEP]) begin
            any_o = 1'b1;
            src_o = SRC_W'(SRC_SSTEP);
            lvl_o = '1;
        end
        if (per_found_i) begin
            any_o = 1'b1;
            src_o = SRC_W'(NUM_SPEC) + SRC_W'(per_idx_i);
            lvl_o = per_lvl_i;
        end
        for (int i = NUM_FIXED_HI - 1; i >= 0; i--) begin
            if (spec_pend_i[i]) begin
                any_o = 1'b1;
                src_o = SRC_W'(i);
                lvl_o = '1;
            end
        end
    end
endmodule

// File: rtl/irq_resolver.sv
// Module: interrupt priority resolver, top level.
// It latches request pulses and resolves one winner at each sampling strobe.
// It issues a registered one-cycle grant and holds further grants until the
// acknowledge. Assumes configuration inputs are steady around a strobe.
module irq_resolver
    import irq_pkg::*;
#(
    parameter int NUM_PERIPH = 8,
    parameter int LVL_W      = 3,
    localparam int NSRC      = NUM_SPEC + NUM_PERIPH,
    localparam int SRC_W     = $clog2(NSRC),
    localparam int PIDX_W    = (NUM_PERIPH > 1) ? $clog2(NUM_PERIPH) : 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        sample_i,
    input  logic [NUM_SPEC-1:0]         spec_req_i,
    input  logic [NUM_PERIPH-1:0]       per_req_i,
    input  logic [NUM_PERIPH*LVL_W-1:0] per_lvl_i,
    input  logic                        gie_i,
    input  logic [LVL_W-1:0]            cpu_ipl_i,
    input  logic                        ack_i,
    output logic                        grant_valid_o,
    output logic [SRC_W-1:0]            grant_src_o,
    output logic [LVL_W-1:0]            grant_lvl_o
);
    logic [NSRC-1:0]   pend;
    logic [NSRC-1:0]   clr_vec;
    logic              per_found;
    logic [PIDX_W-1:0] per_idx;
    logic [LVL_W-1:0]  per_lvl;
    logic              sel_any;
    logic [SRC_W-1:0]  sel_src;
    logic [LVL_W-1:0]  sel_lvl;
    logic              fire;
    logic              ack_take;
    logic              busy_q;
    logic              valid_q;
    logic [SRC_W-1:0]  src_q;
    logic [LVL_W-1:0]  lvl_q;
    logic              sel_was_pend;

    irq_pend #(.W(NSRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  ({per_req_i, spec_req_i}),
        .clr_i  (clr_vec),
        .pend_o (pend)
    );

    irq_periph_arb #(.NUM_PERIPH(NUM_PERIPH), .LVL_W(LVL_W)) u_arb (
        .pend_i  (pend[NSRC-1:NUM_SPEC]),
        .lvl_i   (per_lvl_i),
        .gie_i   (gie_i),
        .ipl_i   (cpu_ipl_i),
        .found_o (per_found),
        .idx_o   (per_idx),
        .lvl_o   (per_lvl)
    );

    irq_src_sel #(
        .NUM_PERIPH (NUM_PERIPH),
        .LVL_W      (LVL_W),
        .SRC_W      (SRC_W),
        .IDX_W      (PIDX_W)
    ) u_sel (
        .spec_pend_i (pend[NUM_SPEC-1:0]),
        .per_found_i (per_found),
        .per_idx_i   (per_idx),
        .per_lvl_i   (per_lvl),
        .any_o       (sel_any),
        .src_o       (sel_src),
        .lvl_o       (sel_lvl)
    );

    // Decide when to grant and when an acknowledge is honoured.
    always_comb begin
        fire     = sample_i & ~busy_q & sel_any;
        ack_take = ack_i & busy_q;
        clr_vec  = ack_take ? ({{(NSRC-1){1'b0}}, 1'b1} << src_q) : '0;
    end

    // Grant register and outstanding flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            busy_q  <= 1'b0;
            src_q   <= '0;
            lvl_q   <= '0;
        end else begin
            valid_q <= fire;
            if (fire) begin
                busy_q <= 1'b1;
                src_q  <= sel_src;
                lvl_q  <= sel_lvl;
            end else if (ack_take) begin
                busy_q <= 1'b0;
            end
        end
    end

    assign grant_valid_o = valid_q;
    assign grant_src_o   = src_q;
    assign grant_lvl_o   = lvl_q;
    assign sel_was_pend  = pend[sel_src];

    // R3: a grant follows a strobe cycle.
    a_r3_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> $past(sample_i));

    // R3: the grant strobe lasts one cycle.
    a_r3_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |=> !grant_valid_o);

    // R2: the granted source was pending when it was chosen.
    a_r2_winner_pending: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> $past(sel_was_pend));

    // R7: a peripheral grant respects the enable and the processor level.
    a_r7_periph_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && (grant_src_o >= SRC_W'(NUM_SPEC)))
            |-> ($past(gie_i) && (grant_lvl_o > $past(cpu_ipl_i))));

    // R10: no grant while an earlier one is unacknowledged.
    a_r10_no_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> !$past(busy_q));

    // R9: a special winner reports the all-ones level.
    a_r9_special_level: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && (grant_src_o < SRC_W'(NUM_SPEC))) |-> (grant_lvl_o == '1));
endmodule

// File: tb/test_irq_resolver.sv
`timescale 1ns/1ps
module test_irq_resolver;
    localparam int NP = 8;
    localparam int LW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sample = 1'b0;
    logic [7:0]    spec_req = '0;
    logic [NP-1:0] per_req = '0;
    logic [NP*LW-1:0] per_lvl = '0;
    logic          gie = 1'b1;
    logic [LW-1:0] ipl = '0;
    logic          ack = 1'b0;
    logic          gv;
    logic [3:0]    gsrc;
    logic [LW-1:0] glvl;

    int checks = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    irq_resolver #(.NUM_PERIPH(NP), .LVL_W(LW)) i_irq_resolver (
        .clk           (clk),
        .rst_n         (rst_n),
        .sample_i      (sample),
        .spec_req_i    (spec_req),
        .per_req_i     (per_req),
        .per_lvl_i     (per_lvl),
        .gie_i         (gie),
        .cpu_ipl_i     (ipl),
        .ack_i         (ack),
        .grant_valid_o (gv),
        .grant_src_o   (gsrc),
        .grant_lvl_o   (glvl)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic set_lvl(input int k, input int v);
        per_lvl[k*LW +: LW] = LW'(v);
    endtask

    // One-cycle request pulse on any mix of sources.
    task automatic pulse(input logic [7:0] s, input logic [NP-1:0] p);
        @(negedge clk);
        spec_req = s;
        per_req  = p;
        @(negedge clk);
        spec_req = '0;
        per_req  = '0;
    endtask

    task automatic do_ack();
        @(negedge clk);
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    // Strobe once, check the grant and its one-cycle width, optionally acknowledge.
    task automatic strobe(input string tag, input bit ev, input int es, input int el, input bit take);
        @(negedge clk);
        sample = 1'b1;
        @(negedge clk);
        sample = 1'b0;
        chk(tag, "valid", int'(gv), int'(ev));
        if (ev) begin
            chk(tag, "src", int'(gsrc), es);
            chk(tag, "lvl", int'(glvl), el);
        end
        @(negedge clk);
        chk(tag, "pulse end", int'(gv), 0);
        if (ev && take) do_ack();
    endtask

    task automatic t_reset();
        chk("R1", "valid after reset", int'(gv), 0);
        strobe("R1", 1'b0, 0, 0, 1'b0);
    endtask

    task automatic t_strobe_only();
        pulse('0, NP'(1 << 5));
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk("R3", "no strobe no grant", int'(gv), 0);
        end
        strobe("R2", 1'b1, 13, 1, 1'b1);
        strobe("R3", 1'b0, 0, 0, 1'b0);
    endtask

    task automatic t_special_order();
        pulse(8'hFF, NP'(1 << 6));
        for (int s = 0; s < 6; s++) strobe("R4", 1'b1, s, 7, 1'b1);
        strobe("R4", 1'b1, 14, 3, 1'b1);
        strobe("R4", 1'b1, 6, 7, 1'b1);
        strobe("R9", 1'b1, 7, 7, 1'b1);
        strobe("R4", 1'b0, 0, 0, 1'b0);
    endtask

    task automatic t_levels();
        pulse('0, NP'(8'b0000_1011));
        strobe("R5", 1'b1, 11, 7, 1'b1);
        strobe("R5", 1'b1, 9, 5, 1'b1);
        strobe("R9", 1'b1, 8, 2, 1'b1);
    endtask

    task automatic t_tie();
        pulse('0, NP'(8'b0000_0110));
        strobe("R6", 1'b1, 9, 5, 1'b1);
        strobe("R6", 1'b1, 10, 5, 1'b1);
    endtask

    task automatic t_mask();
        pulse('0, NP'(8'b0001_0001));
        ipl = 3'd2;
        strobe("R7", 1'b0, 0, 0, 1'b0);
        ipl = 3'd0;
        gie = 1'b0;
        pulse('0, NP'(8'b0000_0010));
        strobe("R7", 1'b0, 0, 0, 1'b0);
        gie = 1'b1;
        strobe("R7", 1'b1, 9, 5, 1'b1);
        strobe("R7", 1'b1, 8, 2, 1'b1);
        strobe("R7", 1'b0, 0, 0, 1'b0);
        set_lvl(4, 1);
        strobe("R7", 1'b1, 12, 1, 1'b1);
        set_lvl(4, 0);
    endtask

    task automatic t_nonmask();
        gie = 1'b0;
        ipl = 3'd7;
        pulse(8'b0100_0010, NP'(1 << 3));
        strobe("R8", 1'b1, 1, 7, 1'b1);
        strobe("R8", 1'b1, 6, 7, 1'b1);
        strobe("R8", 1'b0, 0, 0, 1'b0);
        gie = 1'b1;
        ipl = 3'd0;
        strobe("R8", 1'b1, 11, 7, 1'b1);
    endtask

    task automatic t_busy();
        pulse('0, NP'(1 << 3));
        strobe("R10", 1'b1, 11, 7, 1'b0);
        pulse('0, NP'(1 << 1));
        strobe("R10", 1'b0, 0, 0, 1'b0);
        do_ack();
        strobe("R10", 1'b1, 9, 5, 1'b1);
        pulse('0, NP'(1 << 0));
        do_ack();
        strobe("R10", 1'b1, 8, 2, 1'b1);
    endtask

    task automatic t_set_wins();
        pulse('0, NP'(1 << 1));
        strobe("R11", 1'b1, 9, 5, 1'b0);
        @(negedge clk);
        ack = 1'b1;
        per_req = NP'(1 << 1);
        @(negedge clk);
        ack = 1'b0;
        per_req = '0;
        strobe("R11", 1'b1, 9, 5, 1'b1);
        strobe("R11", 1'b0, 0, 0, 1'b0);
    endtask

    initial begin
        set_lvl(0, 2); set_lvl(1, 5); set_lvl(2, 5); set_lvl(3, 7);
        set_lvl(4, 0); set_lvl(5, 1); set_lvl(6, 3); set_lvl(7, 4);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_strobe_only();
        t_special_order();
        t_levels();
        t_tie();
        t_mask();
        t_nonmask();
        t_busy();
        t_set_wins();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule